// File: doc/BRIEF.md
# Dual Serial Channel Status and Modem Handshake Controller

This block holds the control and status flags for two asynchronous serial channels. It does not serialize or deserialize data. Instead it owns the transmit holding register and offers each byte to an external shift engine through a valid/load handshake. It also watches the modem lines (carrier detect on both channels, and clear-to-send on both channels) and turns them into receiver-reset and transmit-gating outputs. Each channel raises one interrupt request line.

Software reaches the block through a small register bus. This bus has a 3-bit address, read and write strobes, write data, and combinational read data. Each channel has three locations:
- A control register at 0 + channel.
- A status register at 4 + channel. Reading it has side effects.
- A transmit holding register at 6 + channel. It is write-only.

Channel 1 shares one input pin between clear-to-send and receive data. A control bit picks which of the two the pin serves.

Top module: `ser_stat_top`

## Requirements
- R1: After reset:
  - every control register reads 0;
  - each status register reads 0x01 (transmit-empty set, carrier flag 0, clear-to-send 0) while the modem inputs are low;
  - all irq_o, tx_valid_o and rx_rst_o bits are 0.
- R2: Status bit 1 (carrier flag) reads 1 while the channel's carrier input is high. Modem inputs pass through a two-flop synchronizer first.
- R3: After the carrier input falls, the carrier flag holds 1 until the first status read that follows the fall, and that read clears it. A status read in the same cycle as the synchronized fall does not clear the flag.
- R4: When control bit 0 (receive interrupt enable) is 1, a synchronized rising edge of carrier detect sets a receive interrupt request on irq_o. A status read of that channel clears the request. With the bit at 0, no request is raised.
- R5: When control bit 6 is 0 (auto-enable) and the carrier input is high, rx_rst_o of that channel is 1. When bit 6 is 1, rx_rst_o is 0.
- R6: On channel 1, control bit 3 set to 1 makes the shared pin the clear-to-send input: rxd1_o is held at 1 and status bit 2 shows the synchronized pin. Set to 0, rxd1_o follows the pin directly and status bit 2 reads 0.
- R7: A write to address 6 + channel clears status bit 0 (transmit-empty), raises tx_valid_o and presents the byte on tx_data_o. A one-cycle tx_load_i pulse sets the empty flag back to 1 and drops tx_valid_o.
- R8: A holding-register write in the same cycle as tx_load_i leaves the empty flag at 0, keeps tx_valid_o high and presents the new byte.
- R9: Control bit 2 (I/O stop) does three things:
  - it forces the empty flag to 1 and tx_valid_o to 0;
  - it discards any byte that is held;
  - it ignores holding-register writes while it is set.
- R10: On channel 0, with control bit 6 at 0 and the clear-to-send input high, the empty flag reads 0 and tx_en_o[0] is 0.
- R11: irq_o is 1 when control bit 1 (transmit interrupt enable) is 1 and the channel's empty flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (status reads have side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| dcd_i | input | 2 | Carrier-detect input per channel |
| cts0_i | input | 1 | Clear-to-send input of channel 0 |
| pin1_i | input | 1 | Shared clear-to-send / receive-data pin of channel 1 |
| rxd1_o | output | 1 | Receive data routed to the channel 1 deserializer |
| tx_valid_o | output | 2 | Holding register holds a byte for the shifter |
| tx_data_o | output | 16 | Held byte per channel, channel 0 in bits 7:0 |
| tx_load_i | input | 2 | Shifter took the byte (one-cycle pulse) |
| tx_en_o | output | 2 | Transmitter allowed by clear-to-send gating |
| rx_rst_o | output | 2 | Hold receiver in reset |
| irq_o | output | 2 | Interrupt request per channel |

## Verification
The hardest case is a status read that lands exactly in the cycle the synchronized carrier falls. A design that treats this read as following the fall would clear the flag at once, and software would lose the loss-of-carrier event. The second case is a load pulse that coincides with a new write. A design that gives the load priority would mark the register empty and drop the fresh byte. Other tests cover the following:
- I/O stop must discard a held byte and block later writes.
- Clear-to-send gating must pull the empty flag low.
- A transmit interrupt must follow the empty flag as it falls and recovers.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_TDR  = 3'd6;

  // control bits
  localparam int CB_RIE  = 0;
  localparam int CB_TIE  = 1;
  localparam int CB_STOP = 2;
  localparam int CB_SEL  = 3;
  localparam int CB_MAN  = 6;  // 1 = modem lines do not gate

  // status bits
  localparam int SB_TDRE = 0;
  localparam int SB_DCD  = 1;
  localparam int SB_CTS  = 2;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ser_chan.sv
module ser_chan
  import ser_stat_pkg::*;
#(
  parameter bit AUTO_CTS = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             tdr_wr_i,
  input  logic             stat_rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             dcd_s_i,
  input  logic             cts_s_i,
  input  logic             tx_load_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] stat_o,
  output logic             tx_valid_o,
  output logic [REG_W-1:0] tx_data_o,
  output logic             tx_en_o,
  output logic             rx_rst_o,
  output logic             irq_o,
  output logic             stop_o,
  output logic             tdre_o,
  output logic             dcd_o
);
  logic [REG_W-1:0] ctrl_q, data_q;
  logic dcd_d, dcd_q, rx_pend_q, full_q;
  logic rie, tie, man, cts_block, rise, fell, wr_ok;

  assign rie    = ctrl_q[CB_RIE];
  assign tie    = ctrl_q[CB_TIE];
  assign stop_o = ctrl_q[CB_STOP];
  assign man    = ctrl_q[CB_MAN];

  assign rise  = dcd_s_i & ~dcd_d;
  assign fell  = ~dcd_s_i & dcd_d;
  assign wr_ok = tdr_wr_i & ~stop_o;

  generate
    if (AUTO_CTS) begin : g_cts
      assign cts_block = ~man & cts_s_i;
    end else begin : g_nocts
      assign cts_block = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      dcd_d     <= 1'b0;
      dcd_q     <= 1'b0;
      rx_pend_q <= 1'b0;
      full_q    <= 1'b0;
    end else begin
      if (ctrl_wr_i) ctrl_q <= wdata_i;
      dcd_d <= dcd_s_i;
      // read coincident with fall counts as read-before-fall
      if (dcd_s_i)                dcd_q <= 1'b1;
      else if (stat_rd_i && !fell) dcd_q <= 1'b0;
      if (!rie)           rx_pend_q <= 1'b0;
      else if (rise)      rx_pend_q <= 1'b1;
      else if (stat_rd_i) rx_pend_q <= 1'b0;
      if (stop_o)         full_q <= 1'b0;
      else if (tdr_wr_i)  full_q <= 1'b1;
      else if (tx_load_i) full_q <= 1'b0;
      if (wr_ok) data_q <= wdata_i;
    end
  end

  assign dcd_o      = dcd_s_i | dcd_q;
  assign tdre_o     = stop_o | (~full_q & ~cts_block);
  assign tx_valid_o = full_q & ~stop_o;
  assign tx_data_o  = data_q;
  assign tx_en_o    = ~cts_block;
  assign rx_rst_o   = ~man & dcd_s_i;
  assign irq_o      = rx_pend_q | (tie & tdre_o);
  assign ctrl_o     = ctrl_q;

  always_comb begin
    stat_o          = '0;
    stat_o[SB_TDRE] = tdre_o;
    stat_o[SB_DCD]  = dcd_o;
    stat_o[SB_CTS]  = cts_s_i;
  end
endmodule

// File: rtl/ser_stat_top.sv
module ser_stat_top
  import ser_stat_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rdata_o,
  input  logic [NCH-1:0]         dcd_i,
  input  logic                   cts0_i,
  input  logic                   pin1_i,
  output logic                   rxd1_o,
  output logic [NCH-1:0]         tx_valid_o,
  output logic [NCH*REG_W-1:0]   tx_data_o,
  input  logic [NCH-1:0]         tx_load_i,
  output logic [NCH-1:0]         tx_en_o,
  output logic [NCH-1:0]         rx_rst_o,
  output logic [NCH-1:0]         irq_o
);
  localparam int SW = NCH + 2;

  logic [SW-1:0]    raw, synced;
  logic [NCH-1:0]   dcd_s, cts_s, stop_w, tdre_w, dcd_w;
  logic [REG_W-1:0] ctrl_w [NCH];
  logic [REG_W-1:0] stat_w [NCH];
  logic             sel1;

  assign raw = {pin1_i, cts0_i, dcd_i};

  ser_sync #(.W(SW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign sel1     = ctrl_w[1][CB_SEL];
  assign dcd_s    = synced[NCH-1:0];
  assign cts_s[0] = synced[NCH];
  assign cts_s[1] = synced[NCH+1] & sel1;
  assign rxd1_o   = sel1 ? 1'b1 : pin1_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ser_chan #(.AUTO_CTS(c == 0)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_wr_i (wr_i && addr_i == ADDR_W'(ADDR_CTRL + c)),
      .tdr_wr_i  (wr_i && addr_i == ADDR_W'(ADDR_TDR + c)),
      .stat_rd_i (rd_i && addr_i == ADDR_W'(ADDR_STAT + c)),
      .wdata_i   (wdata_i),
      .dcd_s_i   (dcd_s[c]),
      .cts_s_i   (cts_s[c]),
      .tx_load_i (tx_load_i[c]),
      .ctrl_o    (ctrl_w[c]),
      .stat_o    (stat_w[c]),
      .tx_valid_o(tx_valid_o[c]),
      .tx_data_o (tx_data_o[c*REG_W +: REG_W]),
      .tx_en_o   (tx_en_o[c]),
      .rx_rst_o  (rx_rst_o[c]),
      .irq_o     (irq_o[c]),
      .stop_o    (stop_w[c]),
      .tdre_o    (tdre_w[c]),
      .dcd_o     (dcd_w[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == ADDR_W'(ADDR_CTRL + c)) rdata_o = ctrl_w[c];
      if (addr_i == ADDR_W'(ADDR_STAT + c)) rdata_o = stat_w[c];
    end
  end
endmodule

// File: rtl/ser_stat_chk.sv
module ser_stat_chk
  import ser_stat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [NCH-1:0]    tx_load_i,
  input logic [NCH-1:0]    tx_valid_o,
  input logic [NCH-1:0]    tx_en_o,
  input logic [NCH-1:0]    stop_w,
  input logic [NCH-1:0]    tdre_w,
  input logic [NCH-1:0]    dcd_w
);
  logic tdr0_wr, stat0_rd;
  assign tdr0_wr  = wr_i && addr_i == ADDR_TDR;
  assign stat0_rd = rd_i && addr_i == ADDR_STAT;

  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tdr0_wr && !stop_w[0]) |=> tx_valid_o[0]); // R7

  AST_LOAD_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_i[0] && !tdr0_wr) |=> !tx_valid_o[0]); // R8

  AST_STOP_FORCES_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w[0] |-> (!tx_valid_o[0] && tdre_w[0])); // R9

  AST_DCD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcd_w[0] && !stat0_rd) |=> dcd_w[0]); // R3

  AST_CTS_GATES_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_o[0] && !stop_w[0]) |-> !tdre_w[0]); // R10
endmodule

bind ser_stat_top ser_stat_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .tx_load_i (tx_load_i),
  .tx_valid_o(tx_valid_o),
  .tx_en_o   (tx_en_o),
  .stop_w    (stop_w),
  .tdre_w    (tdre_w),
  .dcd_w     (dcd_w)
);

// File: tb/ser_stat_top_test.sv
module ser_stat_top_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  dcd = '0;
  logic        cts0 = 1'b0, pin1 = 1'b0;
  logic        rxd1;
  logic [1:0]  tx_valid, tx_load = '0, tx_en, rx_rst, irq;
  logic [15:0] tx_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_stat_top uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .dcd_i(dcd), .cts0_i(cts0),
    .pin1_i(pin1), .rxd1_o(rxd1), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_load_i(tx_load), .tx_en_o(tx_en), .rx_rst_o(rx_rst), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1; v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic load_pulse(input int ch);
    @(negedge clk); tx_load[ch] = 1'b1;
    @(negedge clk); tx_load[ch] = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(3'd0, v); chk("R1 ctrl0", 16'(v), 16'h00);
    bus_rd(3'd4, v); chk("R1 stat0", 16'(v), 16'h01);
    bus_rd(3'd5, v); chk("R1 stat1", 16'(v), 16'h01);
    chk("R1 outputs", {10'd0, irq, tx_valid, rx_rst}, 16'h0);
  endtask

  task automatic t_carrier();
    logic [7:0] v;
    bus_wr(3'd0, 8'h41);
    @(negedge clk); dcd[0] = 1'b1; settle();
    chk("R4 rx irq on rise", 16'(irq[0]), 16'h1);
    bus_rd(3'd4, v); chk("R2 dcd high", 16'(v[1]), 16'h1);
    chk("R4 irq cleared by read", 16'(irq[0]), 16'h0);
    @(negedge clk); dcd[0] = 1'b0; settle();
    bus_rd(3'd4, v); chk("R3 sticky after fall", 16'(v[1]), 16'h1);
    bus_rd(3'd4, v); chk("R3 cleared by read", 16'(v[1]), 16'h0);
    // read coinciding with synchronized fall
    @(negedge clk); dcd[0] = 1'b1; settle();
    @(negedge clk); dcd[0] = 1'b0;
    @(negedge clk);
    bus_rd(3'd4, v); chk("R3 same-cycle read", 16'(v[1]), 16'h1);
    bus_rd(3'd4, v); chk("R3 kept after same-cycle read", 16'(v[1]), 16'h1);
    bus_rd(3'd4, v); chk("R3 later read cleared", 16'(v[1]), 16'h0);
    bus_wr(3'd0, 8'h40);
    @(negedge clk); dcd[0] = 1'b1; settle();
    chk("R4 no irq when disabled", 16'(irq[0]), 16'h0);
    @(negedge clk); dcd[0] = 1'b0; settle();
    bus_rd(3'd4, v);
  endtask

  task automatic t_auto_rx();
    bus_wr(3'd0, 8'h00);
    @(negedge clk); dcd[0] = 1'b1; settle();
    chk("R5 rx held in reset", 16'(rx_rst[0]), 16'h1);
    bus_wr(3'd0, 8'h40);
    chk("R5 manual releases", 16'(rx_rst[0]), 16'h0);
    @(negedge clk); dcd[0] = 1'b0; settle();
  endtask

  task automatic t_pin_sel();
    logic [7:0] v;
    bus_wr(3'd1, 8'h40);
    @(negedge clk); pin1 = 1'b0; #1;
    chk("R6 rxd follows pin low", 16'(rxd1), 16'h0);
    @(negedge clk); pin1 = 1'b1; settle();
    chk("R6 rxd follows pin high", 16'(rxd1), 16'h1);
    bus_rd(3'd5, v); chk("R6 cts bit off when rx", 16'(v[2]), 16'h0);
    @(negedge clk); pin1 = 1'b0;
    bus_wr(3'd1, 8'h48);
    chk("R6 rxd held high", 16'(rxd1), 16'h1);
    @(negedge clk); pin1 = 1'b1; settle();
    bus_rd(3'd5, v); chk("R6 cts visible", 16'(v[2]), 16'h1);
    @(negedge clk); pin1 = 1'b0;
    bus_wr(3'd1, 8'h40);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    bus_wr(3'd0, 8'h40);
    bus_wr(3'd6, 8'hA5);
    chk("R7 valid after write", 16'(tx_valid[0]), 16'h1);
    chk("R7 data", 16'(tx_data[7:0]), 16'hA5);
    bus_rd(3'd4, v); chk("R7 empty cleared", 16'(v[0]), 16'h0);
    load_pulse(0);
    bus_rd(3'd4, v); chk("R7 empty after load", 16'(v[0]), 16'h1);
    chk("R7 valid dropped", 16'(tx_valid[0]), 16'h0);
    bus_wr(3'd7, 8'h3E);
    chk("R7 ch1 valid", {6'd0, tx_data[15:8], 2'(tx_valid)}, {6'd0, 8'h3E, 2'b10});
    load_pulse(1);
    chk("R7 ch1 emptied", 16'(tx_valid[1]), 16'h0);
  endtask

  task automatic t_load_write();
    logic [7:0] v;
    bus_wr(3'd6, 8'h5A);
    @(negedge clk); addr = 3'd6; wdata = 8'h3C; wr = 1'b1; tx_load[0] = 1'b1;
    @(negedge clk); wr = 1'b0; tx_load[0] = 1'b0;
    chk("R8 stays valid", 16'(tx_valid[0]), 16'h1);
    chk("R8 new byte", 16'(tx_data[7:0]), 16'h3C);
    bus_rd(3'd4, v); chk("R8 empty stays 0", 16'(v[0]), 16'h0);
    load_pulse(0);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    bus_wr(3'd6, 8'h11);
    bus_wr(3'd0, 8'h44);
    chk("R9 valid dropped", 16'(tx_valid[0]), 16'h0);
    bus_rd(3'd4, v); chk("R9 empty forced", 16'(v[0]), 16'h1);
    bus_wr(3'd6, 8'h22);
    chk("R9 write ignored", 16'(tx_valid[0]), 16'h0);
    bus_wr(3'd0, 8'h40);
    chk("R9 byte discarded", 16'(tx_valid[0]), 16'h0);
    bus_rd(3'd4, v); chk("R9 empty after stop", 16'(v[0]), 16'h1);
  endtask

  task automatic t_cts();
    logic [7:0] v;
    bus_wr(3'd0, 8'h00);
    @(negedge clk); cts0 = 1'b1; settle();
    bus_rd(3'd4, v); chk("R10 empty reads 0", 16'(v[0]), 16'h0);
    chk("R10 tx gated", 16'(tx_en[0]), 16'h0);
    bus_wr(3'd0, 8'h40);
    bus_rd(3'd4, v); chk("R10 manual ungated", 16'(v[0]), 16'h1);
    chk("R10 tx enabled", 16'(tx_en[0]), 16'h1);
    @(negedge clk); cts0 = 1'b0; settle();
  endtask

  task automatic t_tx_irq();
    bus_wr(3'd0, 8'h42);
    chk("R11 irq when empty", 16'(irq[0]), 16'h1);
    bus_wr(3'd6, 8'h77);
    chk("R11 irq off when full", 16'(irq[0]), 16'h0);
    load_pulse(0);
    chk("R11 irq back", 16'(irq[0]), 16'h1);
    bus_wr(3'd0, 8'h40);
    chk("R11 irq off when disabled", 16'(irq[0]), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_carrier();
    t_auto_rx();
    t_pin_sel();
    t_tx();
    t_load_write();
    t_stop();
    t_cts();
    t_tx_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule